// File: doc/BRIEF.md
# Direct-Mapped Cache Controller with Fill-Based Initialization

This controller joins a CPU word port to a DRAM port that moves whole lines. It keeps a tag array with one dirty flag per line and a data array, both internal register memories. A request is accepted when `cpu_ready` is high. The controller decides hit or miss from the tag compare and completes the access with a one-cycle `cpu_done` pulse that carries `cpu_rdata`. The write policy is selected by `cfg_wt`: 1 means write-through, 0 means write-back. Three further controls set how the cache behaves: enable, directory freeze, and initialization. All four are sampled when a request is accepted.

The tag array has no valid flags, so its contents after power-up are arbitrary. Software brings the cache into a known state by setting `cfg_init` and reading a span at least as large as the cache. In this mode every read misses and refills its line, and no line is ever written back. To flush dirty data before the cache is disabled, or before switching from write-back to write-through, software reads a span twice the cache size, so that every dirty line is forced out through a miss.

A word address (`ADDR_W`=12 by default) splits into three fields: offset in bits [1:0], line index in bits [4:2], and tag in bits [11:5]. The DRAM port carries a line address, which is the word address without its offset bits. Each word in a line has its own lane-enable bit, and lane w covers bits [16w+15:16w].

Top module: `dm_cache_ctrl`

## Requirements
- R1: After reset, `cpu_ready` is 1 and `dram_req` and `cpu_done` are both 0. `cpu_done` is high for exactly one cycle per request.
- R2: While `cfg_init` is 1, every read refills its line from DRAM, even when the tag matches. This also holds when `cfg_enable` is 0.
- R3: While `cfg_init` is 1, no castout is issued, even when the missed line is dirty. A line filled in this mode starts clean, so write-back data held in it before the fill is lost.
- R4: `cfg_init` overrides `cfg_freeze`. Fills made during initialization update the tag, so later reads of those lines are hits.
- R5: A read hit returns the cached word and makes no DRAM access.
- R6: A read miss on a dirty line first writes the old line to DRAM, at the line address formed from the old tag and the index, with all lane enables set. It then fills the new line.
- R7: After a fill, the CPU word is read from the just-filled cache line. `cpu_done` rises two cycles after the cycle in which the fill acknowledge is high. A DRAM pass-through read completes one cycle after its acknowledge.
- R8: A write-through hit updates the cached word and writes that single word to DRAM. It does not set the dirty flag.
- R9: A write-back hit updates only the cached word, sets the dirty flag, and makes no DRAM access.
- R10: A write miss writes the word to DRAM and allocates no line, so a later read of that address misses.
- R11: With `cfg_enable`=0 and `cfg_init`=0, reads and writes go straight to DRAM and both arrays stay unchanged.
- R12: With `cfg_freeze`=1 and `cfg_init`=0, a read miss is served from DRAM and leaves the tag, the dirty flag and the line data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Cache enable |
| cfg_freeze | input | 1 | Freeze the tag directory on read misses |
| cfg_init | input | 1 | Initialization mode |
| cfg_wt | input | 1 | 1 = write-through, 0 = write-back |
| cpu_req | input | 1 | Request strobe, taken when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | WORD_W | Write word |
| cpu_ready | output | 1 | Controller idle and able to accept a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | WORD_W | Read word, valid with `cpu_done` |
| dram_req | output | 1 | DRAM request, held until acknowledged |
| dram_we | output | 1 | 1 = write, 0 = line read |
| dram_addr | output | ADDR_W-OFS_W | Line address |
| dram_wmask | output | 2**OFS_W | Per-word lane enables for writes |
| dram_wline | output | WORD_W*2**OFS_W | Write line |
| dram_ack | input | 1 | One-cycle acknowledge; read line valid with it |
| dram_rline | input | WORD_W*2**OFS_W | Read line |

## Verification
A wrong tag or dirty flag shows up within one request as an unexpected DRAM operation. A false hit produces no line read where one is expected. A stale dirty flag produces a surplus castout on the next miss, and a lost dirty flag leaves DRAM holding the old data once the line is evicted. Corrupted line data appears in `cpu_rdata` on the first hit to that word. A fill that returns the CPU word straight from DRAM instead of from the array shows up as a completion one cycle too early, measured from the acknowledge. Mode leaks, such as a castout during initialization or a tag update while frozen or disabled, are caught by the next access to the affected index, which hits or misses against expectation.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ACT, S_CAST, S_FILL, S_CRD, S_PASS, S_WRD, S_RESP
  } cc_state_e;

  typedef enum logic [2:0] {
    A_HIT_RD, A_HIT_WB, A_HIT_WT, A_WR_MISS,
    A_FILL, A_CAST_FILL, A_PASS_RD, A_PASS_WR
  } cc_action_e;

endpackage

// File: rtl/cc_policy.sv
module cc_policy
  import cc_pkg::*;
(
  input  logic       active,
  input  logic       init,
  input  logic       freeze,
  input  logic       wt,
  input  logic       we,
  input  logic       tag_match,
  input  logic       dirty,
  output cc_action_e action
);

  always_comb begin
    if (!active) begin
      action = we ? A_PASS_WR : A_PASS_RD;
    end else if (we) begin
      if (tag_match) action = wt ? A_HIT_WT : A_HIT_WB;
      else           action = A_WR_MISS;
    end else if (tag_match && !init) begin
      action = A_HIT_RD;
    end else if (freeze && !init) begin
      action = A_PASS_RD;
    end else if (dirty && !init) begin
      action = A_CAST_FILL;
    end else begin
      action = A_FILL;
    end
  end

endmodule

// File: rtl/cc_tag_store.sv
module cc_tag_store #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 7,
  localparam int LINES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_dirty,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             tag_we,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             dirty_we,
  input  logic             dirty_val
);

  logic [TAG_W-1:0] tag_mem   [LINES];
  logic             dirty_mem [LINES];

  always_ff @(posedge clk) begin
    if (tag_we)   tag_mem[wr_idx]   <= wr_tag;
    if (dirty_we) dirty_mem[wr_idx] <= dirty_val;
  end

  assign rd_tag   = tag_mem[rd_idx];
  assign rd_dirty = dirty_mem[rd_idx];

endmodule

// File: rtl/cc_data_store.sv
module cc_data_store #(
  parameter int WORD_W = 16,
  parameter int OFS_W  = 2,
  parameter int IDX_W  = 3,
  localparam int WPL    = 1 << OFS_W,
  localparam int LINES  = 1 << IDX_W,
  localparam int LINE_W = WORD_W * WPL
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              we,
  input  logic [WPL-1:0]    wmask,
  input  logic [LINE_W-1:0] wline
);

  for (genvar w = 0; w < WPL; w++) begin : g_lane
    logic [WORD_W-1:0] lane_mem [LINES];

    always_ff @(posedge clk) begin
      if (we && wmask[w]) lane_mem[wr_idx] <= wline[w*WORD_W +: WORD_W];
    end

    assign rd_line[w*WORD_W +: WORD_W] = lane_mem[rd_idx];
  end

endmodule

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl
  import cc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16,
  parameter int OFS_W  = 2,
  parameter int IDX_W  = 3,
  localparam int WPL    = 1 << OFS_W,
  localparam int TAG_W  = ADDR_W - IDX_W - OFS_W,
  localparam int LA_W   = ADDR_W - OFS_W,
  localparam int LINE_W = WORD_W * WPL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_freeze,
  input  logic              cfg_init,
  input  logic              cfg_wt,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              dram_req,
  output logic              dram_we,
  output logic [LA_W-1:0]   dram_addr,
  output logic [WPL-1:0]    dram_wmask,
  output logic [LINE_W-1:0] dram_wline,
  input  logic              dram_ack,
  input  logic [LINE_W-1:0] dram_rline
);

  // Address arithmetic
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
    return a[OFS_W +: IDX_W];
  endfunction

  function automatic logic [OFS_W-1:0] f_ofs(input logic [ADDR_W-1:0] a);
    return a[OFS_W-1:0];
  endfunction

  function automatic logic [WPL-1:0] f_lane(input logic [OFS_W-1:0] o);
    return WPL'(1) << o;
  endfunction

  function automatic logic [LINE_W-1:0] f_spread(input logic [WORD_W-1:0] w);
    return {WPL{w}};
  endfunction

  function automatic logic [WORD_W-1:0] f_pick(input logic [LINE_W-1:0] l,
                                               input logic [OFS_W-1:0]  o);
    return l[o*WORD_W +: WORD_W];
  endfunction

  cc_state_e         state;
  logic              q_we, q_active, q_init, q_freeze, q_wt;
  logic [ADDR_W-1:0] q_addr;
  logic [WORD_W-1:0] q_wdata;
  logic [WORD_W-1:0] rdata_q;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  rd_tag;
  logic              rd_dirty;
  logic [LINE_W-1:0] rd_line;
  logic              tag_match;
  cc_action_e        action;

  logic              tag_we, dirty_we, dirty_val, data_we;
  logic [WPL-1:0]    data_wmask;
  logic [LINE_W-1:0] data_wline;

  // Named internal events
  logic ev_rd_hit, ev_wb_hit, ev_wt_hit, ev_castout, ev_fill;

  assign idx       = f_idx(q_addr);
  assign tag_match = (rd_tag == f_tag(q_addr));

  cc_policy u_policy (
    .active    (q_active),
    .init      (q_init),
    .freeze    (q_freeze),
    .wt        (q_wt),
    .we        (q_we),
    .tag_match (tag_match),
    .dirty     (rd_dirty),
    .action    (action)
  );

  assign ev_rd_hit  = (state == S_ACT) && (action == A_HIT_RD);
  assign ev_wb_hit  = (state == S_ACT) && (action == A_HIT_WB);
  assign ev_wt_hit  = (state == S_ACT) && (action == A_HIT_WT);
  assign ev_castout = (state == S_CAST) && dram_ack;
  assign ev_fill    = (state == S_FILL) && dram_ack;

  // Array write controls
  assign tag_we     = ev_fill;
  assign dirty_we   = ev_fill || ev_wb_hit;
  assign dirty_val  = ev_wb_hit;
  assign data_we    = ev_fill || ev_wb_hit || ev_wt_hit;
  assign data_wmask = ev_fill ? {WPL{1'b1}} : f_lane(f_ofs(q_addr));
  assign data_wline = ev_fill ? dram_rline : f_spread(q_wdata);

  cc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rd_idx    (idx),
    .rd_tag    (rd_tag),
    .rd_dirty  (rd_dirty),
    .wr_idx    (idx),
    .tag_we    (tag_we),
    .wr_tag    (f_tag(q_addr)),
    .dirty_we  (dirty_we),
    .dirty_val (dirty_val)
  );

  cc_data_store #(.WORD_W(WORD_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_data (
    .clk     (clk),
    .rd_idx  (idx),
    .rd_line (rd_line),
    .wr_idx  (idx),
    .we      (data_we),
    .wmask   (data_wmask),
    .wline   (data_wline)
  );

  // Sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      q_we     <= 1'b0;
      q_active <= 1'b0;
      q_init   <= 1'b0;
      q_freeze <= 1'b0;
      q_wt     <= 1'b0;
      q_addr   <= '0;
      q_wdata  <= '0;
      rdata_q  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (cpu_req) begin
          q_we     <= cpu_we;
          q_addr   <= cpu_addr;
          q_wdata  <= cpu_wdata;
          q_active <= cfg_enable || cfg_init;
          q_init   <= cfg_init;
          q_freeze <= cfg_freeze;
          q_wt     <= cfg_wt;
          state    <= S_ACT;
        end
        S_ACT: begin
          unique case (action)
            A_HIT_RD: begin
              rdata_q <= f_pick(rd_line, f_ofs(q_addr));
              state   <= S_RESP;
            end
            A_HIT_WB:                state <= S_RESP;
            A_HIT_WT, A_WR_MISS,
            A_PASS_WR:               state <= S_WRD;
            A_PASS_RD:               state <= S_PASS;
            A_FILL:                  state <= S_FILL;
            A_CAST_FILL:             state <= S_CAST;
            default:                 state <= S_RESP;
          endcase
        end
        S_CAST: if (dram_ack) state <= S_FILL;
        S_FILL: if (dram_ack) state <= S_CRD;
        S_CRD: begin
          rdata_q <= f_pick(rd_line, f_ofs(q_addr));
          state   <= S_RESP;
        end
        S_PASS: if (dram_ack) begin
          rdata_q <= f_pick(dram_rline, f_ofs(q_addr));
          state   <= S_RESP;
        end
        S_WRD:  if (dram_ack) state <= S_RESP;
        S_RESP: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // Port drive
  assign cpu_ready  = (state == S_IDLE);
  assign cpu_done   = (state == S_RESP);
  assign cpu_rdata  = rdata_q;
  assign dram_req   = (state == S_CAST) || (state == S_FILL) ||
                      (state == S_PASS) || (state == S_WRD);
  assign dram_we    = (state == S_CAST) || (state == S_WRD);
  assign dram_addr  = (state == S_CAST) ? {rd_tag, idx} : q_addr[ADDR_W-1:OFS_W];
  assign dram_wmask = (state == S_CAST) ? {WPL{1'b1}} :
                      (state == S_WRD)  ? f_lane(f_ofs(q_addr)) : '0;
  assign dram_wline = (state == S_CAST) ? rd_line : f_spread(q_wdata);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !dram_req);
  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
  // R2
  rd_hit_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_hit |-> !q_init);
  // R3
  castout_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CAST) |-> !q_init);
  // R4
  tag_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |-> (q_init || !q_freeze));
  // R6
  cast_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_castout |=> (state == S_FILL) && dram_req && !dram_we);
  // R7
  fill_then_crd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |=> (state == S_CRD) |=> cpu_done);
  // R9
  wb_no_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb_hit |=> cpu_done && !dram_req);
  // R10
  wr_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WRD) |-> !tag_we && dram_we && $onehot0(dram_wmask));
  // R11
  off_arrays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_ready && !q_active) |-> !(tag_we || data_we || dirty_we));

endmodule

// File: tb/dm_cache_ctrl_bench.sv
module dm_cache_ctrl_bench;

  localparam int ADDR_W = 12;
  localparam int WORD_W = 16;
  localparam int OFS_W  = 2;
  localparam int WPL    = 4;
  localparam int LINE_W = 64;
  localparam int NLINES = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              cfg_enable = 0, cfg_freeze = 0, cfg_init = 0, cfg_wt = 0;
  logic              cpu_req = 0, cpu_we = 0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [WORD_W-1:0] cpu_wdata = '0;
  logic              cpu_ready, cpu_done;
  logic [WORD_W-1:0] cpu_rdata;
  logic              dram_req, dram_we;
  logic [ADDR_W-3:0] dram_addr;
  logic [WPL-1:0]    dram_wmask;
  logic [LINE_W-1:0] dram_wline;
  logic              dram_ack;
  logic [LINE_W-1:0] dram_rline;

  dm_cache_ctrl u_dm_cache_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_enable(cfg_enable), .cfg_freeze(cfg_freeze),
    .cfg_init(cfg_init), .cfg_wt(cfg_wt),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
    .cpu_rdata(cpu_rdata),
    .dram_req(dram_req), .dram_we(dram_we), .dram_addr(dram_addr),
    .dram_wmask(dram_wmask), .dram_wline(dram_wline),
    .dram_ack(dram_ack), .dram_rline(dram_rline)
  );

  // Background pattern of DRAM words, derived from the word address
  function automatic logic [15:0] pat(input logic [11:0] a);
    return {a[3:0], a} ^ 16'hA5C3;
  endfunction

  // DRAM model
  logic [LINE_W-1:0] dmem [NLINES];
  int   cyc = 0, ack_cyc = 0, drd = 0, dwr = 0;
  logic [ADDR_W-3:0] last_waddr = '0;
  logic [WPL-1:0]    last_wmask = '0;

  initial begin
    for (int l = 0; l < NLINES; l++)
      for (int w = 0; w < WPL; w++)
        dmem[l][w*16 +: 16] = pat(12'(l*4 + w));
  end

  initial begin
    dram_ack = 1'b0;
    dram_rline = '0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      dram_ack <= 1'b0;
    end else if (dram_req && !dram_ack) begin
      dram_ack <= 1'b1;
      ack_cyc  <= cyc + 1;
      if (dram_we) begin
        for (int w = 0; w < WPL; w++)
          if (dram_wmask[w]) dmem[dram_addr][w*16 +: 16] <= dram_wline[w*16 +: 16];
        dwr        <= dwr + 1;
        last_waddr <= dram_addr;
        last_wmask <= dram_wmask;
      end else begin
        dram_rline <= dmem[dram_addr];
        drd        <= drd + 1;
      end
    end else begin
      dram_ack <= 1'b0;
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [11:0] a, input logic [15:0] d,
                        output logic [15:0] rd, output int lat);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 0;
    while (!cpu_done) @(negedge clk);
    rd  = cpu_rdata;
    lat = cyc - ack_cyc;
  endtask

  // Vector: we, wt, addr, wdata, expected read, DRAM reads, DRAM writes
  localparam int NV = 11;
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 1'b0, 12'd5,  16'h0000, pat(12'd5),  2'd0, 2'd0},
    {1'b1, 1'b0, 12'd5,  16'h1111, 16'h0000,    2'd0, 2'd0},
    {1'b0, 1'b0, 12'd5,  16'h0000, 16'h1111,    2'd0, 2'd0},
    {1'b0, 1'b0, 12'd37, 16'h0000, pat(12'd37), 2'd1, 2'd1},
    {1'b0, 1'b0, 12'd6,  16'h0000, pat(12'd6),  2'd1, 2'd0},
    {1'b0, 1'b0, 12'd5,  16'h0000, 16'h1111,    2'd0, 2'd0},
    {1'b1, 1'b0, 12'd40, 16'h2222, 16'h0000,    2'd0, 2'd1},
    {1'b0, 1'b0, 12'd40, 16'h0000, 16'h2222,    2'd1, 2'd0},
    {1'b1, 1'b1, 12'd41, 16'h3333, 16'h0000,    2'd0, 2'd1},
    {1'b0, 1'b1, 12'd41, 16'h0000, 16'h3333,    2'd0, 2'd0},
    {1'b0, 1'b1, 12'd9,  16'h0000, pat(12'd9),  2'd1, 2'd0}
  };

  task automatic step(input bit we, input logic [11:0] a, input logic [15:0] d,
                      input logic [15:0] exp, input int erd, input int ewr,
                      input int elat, input string req);
    logic [15:0] rd;
    int lat, r0, w0;
    r0 = drd; w0 = dwr;
    access(we, a, d, rd, lat);
    if (!we) chk(rd == exp, req, rd, exp);
    chk(drd - r0 == erd, req, drd - r0, erd);
    chk(dwr - w0 == ewr, req, dwr - w0, ewr);
    if (elat > 0) chk(lat == elat, req, lat, elat);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int lat;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cpu_ready == 1'b1, "R1 ready", cpu_ready, 1);
    chk(dram_req == 1'b0,  "R1 dram_req", dram_req, 0);
    chk(cpu_done == 1'b0,  "R1 done", cpu_done, 0);
    rst_n = 1;
    @(negedge clk);
    chk(cpu_ready == 1'b1, "R1 ready after release", cpu_ready, 1);

    // R2 R4: init sweep with the cache disabled and the directory frozen
    cfg_init = 1; cfg_enable = 0; cfg_freeze = 1; cfg_wt = 0;
    begin
      int r0 = drd, w0 = dwr;
      for (int a = 0; a < 32; a++) begin
        access(1'b0, 12'(a), 16'h0, rd, lat);
        chk(rd == pat(12'(a)), "R2 init read data", rd, pat(12'(a)));
        chk(lat == 2, "R7 fill latency", lat, 2);
      end
      chk(drd - r0 == 32, "R2 every init read fills", drd - r0, 32);
      chk(dwr - w0 == 0,  "R3 no castout in init", dwr - w0, 0);
    end
    cfg_init = 0; cfg_enable = 1; cfg_freeze = 0;

    // Table walk: R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      cfg_wt = VEC[i][48];
      step(VEC[i][49], VEC[i][47:36], VEC[i][35:20], VEC[i][19:4],
           int'(VEC[i][3:2]), int'(VEC[i][1:0]),
           (VEC[i][3:2] != 0) ? 2 : 0, "R5 R6 R7 R8 R9 R10 table");
      if (i == 3) begin
        chk(last_waddr == 10'd1, "R6 castout address", last_waddr, 1);
        chk(last_wmask == 4'hF,  "R6 castout lanes", last_wmask, 4'hF);
        chk(dmem[1][16 +: 16] == 16'h1111, "R6 castout data",
            dmem[1][16 +: 16], 16'h1111);
      end
      if (i == 6)
        chk(dmem[10][0 +: 16] == 16'h2222, "R10 write miss in DRAM",
            dmem[10][0 +: 16], 16'h2222);
      if (i == 8)
        chk(dmem[10][16 +: 16] == 16'h3333, "R8 write-through word in DRAM",
            dmem[10][16 +: 16], 16'h3333);
    end

    // R3: dirty line refilled in init mode is not cast out
    cfg_wt = 0;
    step(1'b1, 12'd10, 16'h4444, 16'h0, 0, 0, 0, "R9 dirty write");
    cfg_init = 1;
    step(1'b0, 12'd42, 16'h0, pat(12'd42), 1, 0, 2, "R3 init miss on dirty line");
    cfg_init = 0;
    step(1'b0, 12'd10, 16'h0, pat(12'd10), 1, 0, 2, "R3 dirty data dropped");

    // R2: tag matches but init forces a refill
    cfg_init = 1;
    step(1'b0, 12'd10, 16'h0, pat(12'd10), 1, 0, 2, "R2 forced miss on match");
    cfg_init = 0;

    // R12: frozen directory
    cfg_freeze = 1;
    step(1'b0, 12'd64, 16'h0, pat(12'd64), 1, 0, 1, "R12 frozen miss from DRAM");
    step(1'b0, 12'd0,  16'h0, pat(12'd0),  0, 0, 0, "R12 old tag still hits");
    cfg_freeze = 0;

    // R11: disabled pass-through leaves the arrays alone
    cfg_enable = 0;
    step(1'b1, 12'd1, 16'h5555, 16'h0, 0, 1, 0, "R11 write to DRAM");
    step(1'b0, 12'd1, 16'h0, 16'h5555, 1, 0, 1, "R11 read from DRAM");
    cfg_enable = 1;
    step(1'b0, 12'd1, 16'h0, pat(12'd1), 0, 0, 0, "R11 array unchanged");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule